// File: doc/BRIEF.md
# Latched Fault Status and Interrupt Controller

This block collects the protection flags of a regulated power output into one 8-bit status word. It decides when the output may be driven, and it drives an open-drain interrupt line toward a host. Three faults are latched: over-current, over-temperature and input under-voltage. Any one of them forces the output off and requests attention. Two further bits, output-disabled and power-not-good, are live views that follow their conditions directly and never interrupt.

The current-limit flag counts as a fault only after it has stayed high for a qualification time. That time is measured in millisecond ticks taken from a parameterized clock divider. The serial interface gives two strobes. A capture strobe copies the live status into a read register at the point in a read where the data byte is committed. A read-done strobe marks the end of that read. Each latched bit clears on read-done only if the bit was shown in the captured byte and its condition has since gone away. A fault that arrives after the capture keeps the interrupt asserted through that read.

Top module: `pwr_fault_monitor`

## Requirements
- R1: After synchronous reset, no fault is latched, the interrupt request is 0, the read register is 8'h00, and with the enable input low the live status is 8'h11.
- R2: Over-current latches only after `ilim_i` is sampled high on CLK_PER_MS*QUAL_MS consecutive clock edges. If it is low on any edge, the count restarts and nothing latches. The bit is visible right after the last qualifying edge.
- R3: Latching over-current, over-temperature or under-voltage turns `out_en_o` off and sets status bit 0 in the same cycle.
- R4: A latched bit stays 1 while its condition is present, even across reads. It clears on a read-done strobe only when its condition is absent and the read register shows that bit as 1.
- R5: Status bit 0 (disabled) equals NOT `out_en_o`. Status bit 4 (power not good) is 1 when the output is off or `pwr_ok_i` is low. Neither bit latches or raises the interrupt.
- R6: `irq_pull_o` rises in the cycle after any latched fault bit goes from 0 to 1.
- R7: The first cycle in which `supply_ok_i` is high after reset raises `irq_pull_o`. A read-done strobe releases it.
- R8: A fault newly latched after a capture strobe keeps `irq_pull_o` at 1 through the next read-done strobe, and that read does not clear its bit.
- R9: A capture strobe copies the live status into `rd_data_o` on the next edge. The bit map is: bit 7 under-voltage, bit 6 over-temperature, bit 4 power not good, bit 2 over-current, bit 0 disabled. Bits 1, 3 and 5 are always 0.
- R10: `out_en_o` is 1 exactly when `enable_i` is 1 and no fault bit is latched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Host request to turn the output on |
| supply_ok_i | input | 1 | Supplies have reached valid levels |
| ilim_i | input | 1 | Output current-limit comparator flag |
| otemp_i | input | 1 | Over-temperature comparator flag |
| uvlo_i | input | 1 | Input under-voltage comparator flag |
| pwr_ok_i | input | 1 | Output voltage is inside its window |
| capture_i | input | 1 | Strobe that copies the status into the read register |
| read_done_i | input | 1 | Strobe marking completion of a status read |
| out_en_o | output | 1 | Output stage enable |
| irq_pull_o | output | 1 | 1 = pull the open-drain interrupt line low |
| status_o | output | 8 | Live status word |
| rd_data_o | output | 8 | Captured read register |

## Verification
The bench holds the current-limit flag for one cycle short of the qualification window. It then drops the flag and starts again. A design whose timer does not restart, or that is off by one edge, latches too early or too late. Reads are issued while a condition is still present and again after it has cleared. This catches a design that clears on any read or only on condition removal. A fault injected between capture and read-done checks that the interrupt survives the read and the unreported bit stays set; a design that loses it drops both. Long random sequences with a cycle model check the live bits for unwanted latching or interrupts.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

    localparam int unsigned NUM_LAT = 3;

    typedef enum logic [1:0] {
        LAT_OCP = 2'd0,
        LAT_TSD = 2'd1,
        LAT_UV  = 2'd2
    } lat_idx_e;

    // position of each latched fault inside the status word
    localparam int unsigned LAT_BIT [NUM_LAT] = '{2, 6, 7};

    typedef struct packed {
        logic uv;
        logic tsd;
        logic rsv5;
        logic png;
        logic rsv3;
        logic ocp;
        logic rsv1;
        logic dis;
    } stat_t;

    function automatic stat_t pack_status(input logic [NUM_LAT-1:0] lat,
                                          input logic out_on,
                                          input logic pwr_ok);
        stat_t s;
        s      = '0;
        s.dis  = ~out_on;
        s.png  = ~out_on | ~pwr_ok;
        s.ocp  = lat[LAT_OCP];
        s.tsd  = lat[LAT_TSD];
        s.uv   = lat[LAT_UV];
        return s;
    endfunction

endpackage

// File: rtl/pfm_ocp_qual.sv
module pfm_ocp_qual #(
    parameter int unsigned CLK_PER_MS = 50000,
    parameter int unsigned QUAL_MS    = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic flag_i,
    output logic evt_o
);
    localparam int unsigned PW = $clog2(CLK_PER_MS + 1);
    localparam int unsigned MW = $clog2(QUAL_MS + 1);
    localparam logic [PW-1:0] P_LAST = PW'(CLK_PER_MS - 1);
    localparam logic [MW-1:0] M_LAST = MW'(QUAL_MS - 1);
    localparam logic [MW-1:0] M_SAT  = MW'(QUAL_MS);

    logic [PW-1:0] pre_q;
    logic [MW-1:0] ms_q;
    logic          tick;

    assign tick  = (pre_q == P_LAST);
    assign evt_o = flag_i && tick && (ms_q == M_LAST);

    always_ff @(posedge clk) begin
        if (rst || !flag_i) begin
            pre_q <= '0;
            ms_q  <= '0;
        end else if (tick) begin
            pre_q <= '0;
            if (ms_q != M_SAT)
                ms_q <= ms_q + 1'b1;
        end else begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // R2: qualification needs the flag high on the previous edge as well
    assert_qual_continuous_R2: assert property (@(posedge clk) disable iff (rst)
        evt_o |-> $past(flag_i));

endmodule

// File: rtl/pfm_fault_bit.sv
module pfm_fault_bit (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic present_i,
    input  logic read_done_i,
    input  logic reported_i,
    output logic lat_o,
    output logic new_o
);
    logic lat_q;
    logic clr;

    assign clr   = read_done_i && reported_i && !present_i;
    assign new_o = set_i && !lat_q;
    assign lat_o = lat_q;

    always_ff @(posedge clk) begin
        if (rst)
            lat_q <= 1'b0;
        else if (set_i)
            lat_q <= 1'b1;
        else if (clr)
            lat_q <= 1'b0;
    end

    assert_hold_present_R4: assert property (@(posedge clk) disable iff (rst)
        (lat_q && present_i) |=> lat_q);

    assert_clear_by_read_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(lat_q) |-> $past(read_done_i));

endmodule

// File: rtl/pfm_irq_ctrl.sv
module pfm_irq_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic new_fault_i,
    input  logic supply_ok_i,
    input  logic capture_i,
    input  logic read_done_i,
    output logic irq_o
);
    logic pow_q;
    logic pend_q;
    logic late_q;
    logic irq_q;
    logic power_up;
    logic event_now;

    assign power_up  = supply_ok_i && !pow_q;
    assign event_now = new_fault_i || power_up;
    assign irq_o     = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pow_q  <= 1'b0;
            pend_q <= 1'b0;
            late_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            pow_q <= pow_q | supply_ok_i;
            if (capture_i) begin
                pend_q <= 1'b1;
                late_q <= event_now;
            end else if (read_done_i) begin
                pend_q <= 1'b0;
                late_q <= 1'b0;
            end else if (pend_q && event_now) begin
                late_q <= 1'b1;
            end
            if (event_now)
                irq_q <= 1'b1;
            else if (read_done_i)
                irq_q <= late_q;
        end
    end

    assert_irq_on_event_R6: assert property (@(posedge clk) disable iff (rst)
        new_fault_i |=> irq_o);

    assert_late_keeps_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (read_done_i && late_q) |=> irq_o);

endmodule

// File: rtl/pwr_fault_monitor.sv
module pwr_fault_monitor
    import pfm_pkg::*;
#(
    parameter int unsigned CLK_PER_MS = 50000,
    parameter int unsigned QUAL_MS    = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       enable_i,
    input  logic       supply_ok_i,
    input  logic       ilim_i,
    input  logic       otemp_i,
    input  logic       uvlo_i,
    input  logic       pwr_ok_i,
    input  logic       capture_i,
    input  logic       read_done_i,
    output logic       out_en_o,
    output logic       irq_pull_o,
    output logic [7:0] status_o,
    output logic [7:0] rd_data_o
);
    logic               ocp_evt;
    logic [NUM_LAT-1:0] set_vec;
    logic [NUM_LAT-1:0] pres_vec;
    logic [NUM_LAT-1:0] lat_vec;
    logic [NUM_LAT-1:0] new_vec;
    stat_t              live;
    logic [7:0]         snap_q;

    pfm_ocp_qual #(
        .CLK_PER_MS(CLK_PER_MS),
        .QUAL_MS   (QUAL_MS)
    ) u_qual (
        .clk   (clk),
        .rst   (rst),
        .flag_i(ilim_i),
        .evt_o (ocp_evt)
    );

    assign set_vec[LAT_OCP]  = ocp_evt;
    assign set_vec[LAT_TSD]  = otemp_i;
    assign set_vec[LAT_UV]   = uvlo_i;
    assign pres_vec[LAT_OCP] = ilim_i;
    assign pres_vec[LAT_TSD] = otemp_i;
    assign pres_vec[LAT_UV]  = uvlo_i;

    for (genvar g = 0; g < NUM_LAT; g++) begin : g_lat
        pfm_fault_bit u_bit (
            .clk        (clk),
            .rst        (rst),
            .set_i      (set_vec[g]),
            .present_i  (pres_vec[g]),
            .read_done_i(read_done_i),
            .reported_i (snap_q[LAT_BIT[g]]),
            .lat_o      (lat_vec[g]),
            .new_o      (new_vec[g])
        );
    end

    pfm_irq_ctrl u_irq (
        .clk        (clk),
        .rst        (rst),
        .new_fault_i(|new_vec),
        .supply_ok_i(supply_ok_i),
        .capture_i  (capture_i),
        .read_done_i(read_done_i),
        .irq_o      (irq_pull_o)
    );

    assign out_en_o  = enable_i && (lat_vec == '0);
    assign live      = pack_status(lat_vec, out_en_o, pwr_ok_i);
    assign status_o  = live;
    assign rd_data_o = snap_q;

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (capture_i)
            snap_q <= live;
    end

    assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
        capture_i |=> (rd_data_o == $past(status_o)));

    assert_off_after_latch_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(status_o[2]) |-> !out_en_o);

endmodule

// File: tb/pwr_fault_monitor_bench.sv
`timescale 1ns/1ps
module pwr_fault_monitor_bench;
    localparam int CPM = 4;
    localparam int QMS = 5;
    localparam int NQ  = CPM * QMS;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_i = 0, supply_ok_i = 0, ilim_i = 0, otemp_i = 0, uvlo_i = 0;
    logic pwr_ok_i = 0, capture_i = 0, read_done_i = 0;
    logic out_en_o, irq_pull_o;
    logic [7:0] status_o, rd_data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pwr_fault_monitor #(.CLK_PER_MS(CPM), .QUAL_MS(QMS)) u_pwr_fault_monitor (
        .clk(clk), .rst(rst), .enable_i(enable_i), .supply_ok_i(supply_ok_i),
        .ilim_i(ilim_i), .otemp_i(otemp_i), .uvlo_i(uvlo_i), .pwr_ok_i(pwr_ok_i),
        .capture_i(capture_i), .read_done_i(read_done_i), .out_en_o(out_en_o),
        .irq_pull_o(irq_pull_o), .status_o(status_o), .rd_data_o(rd_data_o));

    // ---------------- cycle model built from the requirements ----------------
    int       m_run;
    bit [2:0] m_lat;  // 0 ocp, 1 tsd, 2 uv
    bit       m_pow, m_pend, m_late, m_irq;
    bit [7:0] m_snap;

    function automatic bit [7:0] exp_status(bit [2:0] lat, bit en, bit pok);
        bit on;
        on = en && (lat == 3'b000);
        return {lat[2], lat[1], 1'b0, (!on || !pok), 1'b0, lat[0], 1'b0, !on};
    endfunction

    function automatic bit exp_on(bit [2:0] lat, bit en);
        return en && (lat == 3'b000);
    endfunction

    always @(posedge clk) begin
        bit evt, pup, ev;
        bit [2:0] setv, pres, rep, nl;
        bit [7:0] st;
        if (rst) begin
            m_run = 0; m_lat = 0; m_pow = 0; m_pend = 0; m_late = 0; m_irq = 0; m_snap = 0;
        end else begin
            st   = exp_status(m_lat, enable_i, pwr_ok_i);
            evt  = ilim_i && (m_run == NQ - 1);
            m_run = ilim_i ? ((m_run < NQ) ? m_run + 1 : NQ) : 0;
            setv = {uvlo_i, otemp_i, evt};
            pres = {uvlo_i, otemp_i, ilim_i};
            rep  = {m_snap[7], m_snap[6], m_snap[2]};
            nl   = setv & ~m_lat;
            for (int i = 0; i < 3; i++) begin
                if (setv[i]) m_lat[i] = 1;
                else if (read_done_i && rep[i] && !pres[i]) m_lat[i] = 0;
            end
            pup = supply_ok_i && !m_pow;
            ev  = (nl != 0) || pup;
            if (ev) m_irq = 1;
            else if (read_done_i) m_irq = m_late;
            if (capture_i) begin m_pend = 1; m_late = ev; end
            else if (read_done_i) begin m_pend = 0; m_late = 0; end
            else if (m_pend && ev) m_late = 1;
            m_pow = m_pow | supply_ok_i;
            if (capture_i) m_snap = st;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    task automatic nxt(int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic pulse_cap();
        capture_i = 1; nxt(1); capture_i = 0;
    endtask

    task automatic pulse_rd();
        read_done_i = 1; nxt(1); read_done_i = 0;
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        nxt(3);
        rst = 0;
        nxt(1);
        // R1 reset state
        chk("R1 irq", irq_pull_o, 0);
        chk("R1 rd_data", rd_data_o, 8'h00);
        chk("R1 status", status_o, 8'h11);
        chk("R1 out_en", out_en_o, 0);

        // R7 power-up interrupt, R10 enable
        supply_ok_i = 1; enable_i = 1; pwr_ok_i = 1;
        nxt(1);
        chk("R7 irq at power-up", irq_pull_o, 1);
        chk("R10 out_en", out_en_o, 1);
        chk("R5 status clean", status_o, 8'h00);
        pulse_cap();
        pulse_rd();
        chk("R7 irq released", irq_pull_o, 0);

        // R2 one edge short, then restart
        ilim_i = 1; nxt(NQ - 1);
        chk("R2 no early latch", status_o, 8'h00);
        ilim_i = 0; nxt(1);
        ilim_i = 1; nxt(NQ - 1);
        chk("R2 timer restarted", status_o, 8'h00);
        chk("R2 irq quiet", irq_pull_o, 0);
        nxt(1);
        chk("R2 latched at window", status_o, 8'h15);
        chk("R3 output off", out_en_o, 0);
        chk("R6 irq raised", irq_pull_o, 1);

        // R4 read while condition present
        pulse_cap();
        chk("R9 snapshot", rd_data_o, 8'h15);
        pulse_rd();
        chk("R4 held while present", status_o, 8'h15);
        chk("R4 irq released by read", irq_pull_o, 0);
        ilim_i = 0; nxt(1);
        chk("R4 still latched before read", status_o, 8'h15);
        pulse_rd();
        chk("R4 cleared after read", status_o, 8'h00);
        chk("R10 output back on", out_en_o, 1);

        // R8 fault between capture and read-done
        pulse_cap();
        otemp_i = 1; nxt(1); otemp_i = 0;
        chk("R6 irq on tsd", irq_pull_o, 1);
        pulse_rd();
        chk("R8 irq survives read", irq_pull_o, 1);
        chk("R8 bit kept", status_o, 8'h51);
        pulse_cap();
        pulse_rd();
        chk("R8 cleared on next read", status_o, 8'h00);
        chk("R8 irq released", irq_pull_o, 0);

        // R5 live bits
        enable_i = 0; nxt(1);
        chk("R5 disabled live", status_o, 8'h11);
        chk("R5 no irq from disable", irq_pull_o, 0);
        enable_i = 1; pwr_ok_i = 0; nxt(1);
        chk("R5 png live", status_o, 8'h10);
        chk("R5 no irq from png", irq_pull_o, 0);
        pwr_ok_i = 1; nxt(1);
        chk("R5 png follows", status_o, 8'h00);

        // R9 bit map, under-voltage
        uvlo_i = 1; nxt(1); uvlo_i = 0;
        pulse_cap();
        chk("R9 uv snapshot", rd_data_o, 8'h91);
        chk("R9 reserved zero", rd_data_o & 8'h2A, 8'h00);
        pulse_rd();
        chk("R4 uv cleared", status_o, 8'h00);

        // random phase against cycle model
        for (int c = 0; c < 4000; c++) begin
            int r;
            r = $urandom_range(0, 63);
            if (r < 4) ilim_i = ~ilim_i;
            otemp_i   = ($urandom_range(0, 99) < 2);
            uvlo_i    = ($urandom_range(0, 99) < 2);
            enable_i  = ($urandom_range(0, 15) != 0);
            pwr_ok_i  = ($urandom_range(0, 9) != 0);
            r = $urandom_range(0, 15);
            capture_i   = (r < 2);
            read_done_i = (r >= 2 && r < 4);
            nxt(1);
            chk("R10 random out_en", out_en_o, exp_on(m_lat, enable_i));
            chk("R6 random irq", irq_pull_o, m_irq);
            chk("R5 random status", status_o, exp_status(m_lat, enable_i, pwr_ok_i));
            chk("R9 random rd_data", rd_data_o, m_snap);
        end

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule